// File: doc/BRIEF.md
# Port Change-on-Mismatch Detector

This block watches the upper half of an 8-bit input port and raises a change flag when any watched pin that software has enabled no longer matches the value captured at the most recent port read. Each pin first passes through a two-flop synchroniser. The compare runs against a stored snapshot, not against the previous cycle's value. The flag therefore keeps being re-set for as long as the mismatch lasts, however long that is.

Software reads the port to refresh the snapshot. The read also returns the synchronised port value. After the read has ended the mismatch, software issues a clear strobe to drop the flag. A clear issued before that read is overridden, because the mismatch is still present and sets the flag again. The flag feeds an interrupt controller outside this block.

Top module: `port_change_watch`

## Requirements
- R1: Only port bits 7 down to 4 are compared. A change on bits 3 down to 0 never sets the flag.
- R2: Enable bit `chg_en_i[i]` controls pin 4+i. A pin whose enable bit is 0 never sets the flag, and the flag rises only while an enabled mismatch exists.
- R3: When an enabled watched pin changes, the flag reads 1 after the third rising edge and is still 0 after the second. Two edges go to synchronisation and one to the flag register.
- R4: While any enabled pin differs from its snapshot, the flag is set on every edge, so a clear strobe in that state leaves the flag at 1 in the next cycle.
- R5: On a read strobe, the snapshot takes the synchronised bits 7:4 and `rd_data_o` takes the full synchronised 8-bit port, both visible after that edge. Once the read has ended the mismatch, a clear strobe returns the flag to 0 on the next edge.
- R6: The flag is sticky. Once set, it stays 1 until a clear strobe arrives with no mismatch present, even if the pins return to their snapshot values on their own.
- R7: While reset is high, the flag and `rd_data_o` are 0 and the snapshot loads from the synchronised pins. Pins held steady through reset therefore do not raise the flag afterwards, and a later change against that loaded value does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 8 | Asynchronous port pin values |
| chg_en_i | input | 4 | Per-pin change enable; bit i controls pin 4+i |
| rd_stb_i | input | 1 | Port read strobe; refreshes the snapshot |
| clr_stb_i | input | 1 | Software flag clear strobe |
| chg_flag_o | output | 1 | Sticky change flag |
| rd_data_o | output | 8 | Synchronised port value captured at the last read |

## Verification
A table walks eight pin and enable patterns, and a bench-side snapshot model predicts each flag result. The patterns separate four cases: a change on the lower bits only, a change on a disabled upper pin, an enabled change, and a repeat of the snapshot value after a read. Directed tests then cover the following:
- the exact latency edge;
- a clear issued before any read, which must not take effect;
- a mismatch that vanishes on its own, where the flag must stay set until cleared;
- a reset taken with nonzero pins, which shows that the snapshot loads during reset rather than being zeroed.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
    localparam int DEF_PORT_W      = 8;
    localparam int DEF_WATCH_LO    = 4;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;
endpackage

// File: rtl/pcw_sync.sv
module pcw_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcw_snapshot.sv
module pcw_snapshot #(
    parameter int PORT_W   = 8,
    parameter int WATCH_LO = 4,
    localparam int WATCH_W = PORT_W - WATCH_LO
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_stb_i,
    input  logic [PORT_W-1:0]  sync_i,
    output logic [WATCH_W-1:0] snap_o,
    output logic [PORT_W-1:0]  rd_data_o
);
    logic [WATCH_W-1:0] snap_q;
    logic [PORT_W-1:0]  rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= sync_i[PORT_W-1:WATCH_LO];
            rd_q   <= '0;
        end else if (rd_stb_i) begin
            snap_q <= sync_i[PORT_W-1:WATCH_LO];
            rd_q   <= sync_i;
        end
    end

    assign snap_o    = snap_q;
    assign rd_data_o = rd_q;

    // R5
    rd_snap_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb_i |=> (snap_q == $past(sync_i[PORT_W-1:WATCH_LO])));
    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_i |=> $stable(snap_q));
    // R5
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_i |=> $stable(rd_q));
endmodule

// File: rtl/pcw_flag.sv
module pcw_flag
    import pcw_pkg::*;
#(
    parameter int WATCH_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic [WATCH_W-1:0] watch_i,
    input  logic [WATCH_W-1:0] snap_i,
    input  logic [WATCH_W-1:0] en_i,
    output logic               flag_o,
    output logic               mismatch_o
);
    logic [WATCH_W-1:0] diff;
    flag_state_e        state_q;

    for (genvar i = 0; i < WATCH_W; i++) begin : g_cmp
        assign diff[i] = en_i[i] & (watch_i[i] ^ snap_i[i]);
    end

    assign mismatch_o = |diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLAG_IDLE;
        end else if (mismatch_o) begin
            state_q <= FLAG_RAISED;
        end else if (clr_i) begin
            state_q <= FLAG_IDLE;
        end
    end

    assign flag_o = (state_q == FLAG_RAISED);

    // R4
    mm_sets_chk: assert property (@(posedge clk) disable iff (rst)
        mismatch_o |=> flag_o);
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);
    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && !mismatch_o) |=> !flag_o);
    // R5
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && clr_i && !mismatch_o) |=> !flag_o);
endmodule

// File: rtl/port_change_watch.sv
module port_change_watch
    import pcw_pkg::*;
#(
    parameter int PORT_W      = DEF_PORT_W,
    parameter int WATCH_LO    = DEF_WATCH_LO,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int WATCH_W    = PORT_W - WATCH_LO
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PORT_W-1:0]  pins_i,
    input  logic [WATCH_W-1:0] chg_en_i,
    input  logic               rd_stb_i,
    input  logic               clr_stb_i,
    output logic               chg_flag_o,
    output logic [PORT_W-1:0]  rd_data_o
);
    logic [PORT_W-1:0]  sync_pins;
    logic [WATCH_W-1:0] snap;
    logic               mismatch;

    pcw_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (pins_i),
        .q_o (sync_pins)
    );

    pcw_snapshot #(.PORT_W(PORT_W), .WATCH_LO(WATCH_LO)) u_snap (
        .clk       (clk),
        .rst       (rst),
        .rd_stb_i  (rd_stb_i),
        .sync_i    (sync_pins),
        .snap_o    (snap),
        .rd_data_o (rd_data_o)
    );

    pcw_flag #(.WATCH_W(WATCH_W)) u_flag (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr_stb_i),
        .watch_i    (sync_pins[PORT_W-1:WATCH_LO]),
        .snap_i     (snap),
        .en_i       (chg_en_i),
        .flag_o     (chg_flag_o),
        .mismatch_o (mismatch)
    );

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (chg_en_i == '0 && !chg_flag_o) |=> !chg_flag_o);
endmodule

// File: tb/tb_port_change_watch.sv
module tb_port_change_watch;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] pins_i;
    logic [3:0] chg_en_i;
    logic       rd_stb_i;
    logic       clr_stb_i;
    logic       chg_flag_o;
    logic [7:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    port_change_watch dut (
        .clk        (clk),
        .rst        (rst),
        .pins_i     (pins_i),
        .chg_en_i   (chg_en_i),
        .rd_stb_i   (rd_stb_i),
        .clr_stb_i  (clr_stb_i),
        .chg_flag_o (chg_flag_o),
        .rd_data_o  (rd_data_o)
    );

    // {pins, enable, expected flag}
    localparam int NV = 8;
    localparam logic [12:0] VEC [NV] = '{
        {8'h0F, 4'hF, 1'b0},
        {8'h10, 4'hF, 1'b1},
        {8'h90, 4'h7, 1'b0},
        {8'h90, 4'hF, 1'b0},
        {8'h50, 4'h4, 1'b1},
        {8'hA5, 4'h0, 1'b0},
        {8'h25, 4'h8, 1'b1},
        {8'h2F, 4'h1, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read();
        rd_stb_i = 1'b1;
        tick(1);
        rd_stb_i = 1'b0;
    endtask

    task automatic do_clear();
        clr_stb_i = 1'b1;
        tick(1);
        clr_stb_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [3:0] snap_m;
        rst = 1'b1; pins_i = 8'h00; chg_en_i = 4'h0;
        rd_stb_i = 1'b0; clr_stb_i = 1'b0;
        tick(4);
        rst = 1'b0;
        // R7 reset state
        check("R7 flag after reset", {7'd0, chg_flag_o}, 8'h00);
        check("R7 rd_data after reset", rd_data_o, 8'h00);
        snap_m = 4'h0;

        // Table: R1 R2 R4 R5
        for (int k = 0; k < NV; k++) begin
            logic [7:0] p;
            logic [3:0] e;
            logic       x, model;
            {p, e, x} = VEC[k];
            chg_en_i = e;
            pins_i   = p;
            tick(4);
            model = |((p[7:4] ^ snap_m) & e);
            check("R1 R2 flag vs model", {7'd0, chg_flag_o}, {7'd0, model});
            check("R2 flag vs table", {7'd0, chg_flag_o}, {7'd0, x});
            do_read();
            snap_m = p[7:4];
            check("R5 rd_data after read", rd_data_o, p);
            do_clear();
            check("R5 flag cleared after read", {7'd0, chg_flag_o}, 8'h00);
        end

        // R3 latency, pins 2F -> 3F on pin 4
        chg_en_i = 4'hF;
        pins_i   = 8'h3F;
        tick(2);
        check("R3 flag still low after 2 edges", {7'd0, chg_flag_o}, 8'h00);
        tick(1);
        check("R3 flag high after 3 edges", {7'd0, chg_flag_o}, 8'h01);

        // R4 clear before read is overridden
        do_clear();
        check("R4 clear during mismatch", {7'd0, chg_flag_o}, 8'h01);
        tick(3);
        check("R4 flag persists", {7'd0, chg_flag_o}, 8'h01);

        // R6 mismatch vanishes by itself
        pins_i = 8'h2F;
        tick(4);
        check("R6 flag sticky after pins revert", {7'd0, chg_flag_o}, 8'h01);
        do_clear();
        check("R6 clear once mismatch gone", {7'd0, chg_flag_o}, 8'h00);

        // R1 lower pins only
        pins_i = 8'h20;
        tick(5);
        check("R1 lower pin change ignored", {7'd0, chg_flag_o}, 8'h00);

        // R7 reset with nonzero pins loads snapshot
        pins_i = 8'hC0;
        rst = 1'b1;
        tick(4);
        rst = 1'b0;
        check("R7 flag zero after reset", {7'd0, chg_flag_o}, 8'h00);
        check("R7 rd_data zero after reset", rd_data_o, 8'h00);
        tick(5);
        check("R7 steady pins no flag", {7'd0, chg_flag_o}, 8'h00);
        pins_i = 8'h40;
        tick(4);
        check("R7 change vs reset snapshot", {7'd0, chg_flag_o}, 8'h01);

        finish_run();
    end
endmodule